// File: doc/BRIEF.md
# Mode-Bit Instruction Stream Sequencer

This fetch-side unit takes program-order 16-bit parcels and turns them into whole instructions. Each instruction is either one parcel long (compressed) or two parcels long (normal). Nothing in a parcel says how long its instruction is. The length comes from a window of mode bits, and that window is loaded by a special 32-bit prefix instruction. The prefix has three fields. Its top bits hold a major opcode. Below them sits a 10-bit mask, one bit for each of the next ten instructions. The low half holds a compressed instruction that travels with the prefix.

When no prefix is in force, or once its mask is used up, every instruction is decoded as a 32-bit instruction. A prefix is only recognised in an instruction decoded as 32 bits. A newer prefix overwrites whatever is left of the old mask. A taken branch or redirect pulse empties the window and drops any half-built instruction. So does an entry-point pulse. The next instruction after either pulse is therefore decoded as 32 bits.

Both sides use valid/ready handshakes. The emitted beat carries the instruction word, a short flag and a prefix flag. For a prefix it also carries the embedded compressed instruction.

Top module: `modebit_seq`

## Requirements
- R1: After reset, `ins_valid` is 0, `par_ready` is 1 and the mode window is empty, so the first instructions are decoded as 32-bit.
- R2: With the window empty, two accepted parcels form one instruction. The first parcel goes in `ins_word[31:16]` and the second in `ins_word[15:0]`. `ins_short`, `ins_prefix` and `ins_embed` are 0. Nothing is emitted after only the first parcel.
- R3: A 32-bit instruction whose bits [31:26] equal `PFX_OP` is emitted with `ins_prefix`=1 and `ins_short`=0. Its whole 32-bit word is on `ins_word`, and its bits [15:0] are repeated on `ins_embed`.
- R4: A prefix loads its bits [25:16] as the mask. Bit 25 governs the first following instruction and bit 16 the tenth. A set bit makes that instruction a single parcel, emitted with `ins_short`=1 and `ins_word` = {16'h0, parcel}. A clear bit makes it a two-parcel instruction.
- R5: Exactly ten instructions follow a prefix under its mask. The prefix itself does not count as one of them. After those ten, every instruction is 32-bit.
- R6: A prefix arriving while mask bits remain replaces them. The instructions after it follow only the new mask.
- R7: A `redirect` pulse empties the window and discards a held first parcel. `par_ready` is 0 during that cycle, and the next instruction is 32-bit.
- R8: An `entry` pulse has the same effect as `redirect`: the window is emptied, the held parcel is dropped, and `par_ready` is 0 during that cycle.
- R9: While `ins_valid`=1 and `ins_ready`=0, all output fields hold steady and `par_ready` is 0. The mode window is not disturbed by the stall.
- R10: A parcel in a compressed slot is emitted as a short instruction even when its top six bits equal `PFX_OP`. It does not load the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| par_valid | input | 1 | Parcel offered |
| par_ready | output | 1 | Parcel accepted this cycle when valid |
| par_data | input | 16 | Parcel bits |
| redirect | input | 1 | Taken branch / redirect pulse |
| entry | input | 1 | Entry-point pulse |
| ins_valid | output | 1 | Instruction beat present |
| ins_ready | input | 1 | Consumer takes the beat |
| ins_word | output | 32 | Instruction bits, zero-extended when short |
| ins_short | output | 1 | Beat is a compressed instruction |
| ins_prefix | output | 1 | Beat is a prefix instruction |
| ins_embed | output | 16 | Compressed instruction inside a prefix, else 0 |

## Verification
The stimulus covers these cases, and each one separates a different fault:
- Plain two-parcel instructions with no prefix, which exposes a wrong half order or early emission.
- A sparse mask followed by an eleventh instruction, which exposes an off-by-one in the count or a reversed bit order.
- A prefix placed in the only clear slot of a mask that is otherwise all ones, which shows whether the new mask replaces the old one or is appended to it.
- A compressed-slot parcel that carries the prefix opcode, which exposes prefix detection in the wrong slot.
- Redirect and entry pulses while a first parcel is held, which expose stale halves and leftover mask bits.
- A consumer that stalls every third cycle, which checks that the window survives back-pressure.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        SLOT_LONG   = 2'd0,
        SLOT_SHORT  = 2'd1,
        SLOT_PREFIX = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/mbs_window.sv
module mbs_window #(
    parameter int MODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [MODE_W-1:0] load_bits,
    input  logic              consume,
    output logic              active,
    output logic              cur_bit
);
    localparam int CNT_W = $clog2(MODE_W + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mask;
        logic [CNT_W-1:0]  left;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clear) begin
            win_d = '0;
        end else if (load) begin
            win_d.mask = load_bits;
            win_d.left = CNT_W'(MODE_W);
        end else if (consume && (win_q.left != '0)) begin
            win_d.mask = win_q.mask << 1;
            win_d.left = win_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign active  = (win_q.left != '0);
    assign cur_bit = win_q.mask[MODE_W-1];
endmodule

// File: rtl/mbs_asm.sv
module mbs_asm #(
    parameter int PARCEL_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic [PARCEL_W-1:0] parcel,
    output logic                half,
    output logic [PARCEL_W-1:0] hi
);
    typedef struct packed {
        logic                held;
        logic [PARCEL_W-1:0] upper;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d = asm_q;
        if (clear) begin
            asm_d.held = 1'b0;
        end else if (take) begin
            asm_d.held  = 1'b1;
            asm_d.upper = parcel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) asm_q <= '0;
        else        asm_q <= asm_d;
    end

    assign half = asm_q.held;
    assign hi   = asm_q.upper;
endmodule

// File: rtl/modebit_seq.sv
module modebit_seq
    import mbs_pkg::*;
#(
    parameter int              PARCEL_W = 16,
    parameter int              OP_W     = 6,
    parameter int              MODE_W   = 10,
    parameter logic [OP_W-1:0] PFX_OP   = 6'h3B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  par_valid,
    output logic                  par_ready,
    input  logic [PARCEL_W-1:0]   par_data,
    input  logic                  redirect,
    input  logic                  entry,
    output logic                  ins_valid,
    input  logic                  ins_ready,
    output logic [2*PARCEL_W-1:0] ins_word,
    output logic                  ins_short,
    output logic                  ins_prefix,
    output logic [PARCEL_W-1:0]   ins_embed
);
    localparam int WORD_W  = 2 * PARCEL_W;
    localparam int MODE_LO = WORD_W - OP_W - MODE_W;

    typedef struct packed {
        logic                valid;
        slot_kind_e          kind;
        logic [WORD_W-1:0]   word;
        logic [PARCEL_W-1:0] embed;
    } beat_t;

    beat_t beat_d, beat_q;

    logic                half, win_active, win_bit;
    logic [PARCEL_W-1:0] hi;
    logic                flush, stall, fire, short_slot, is_pfx;
    logic [WORD_W-1:0]   full_word;
    logic                asm_take, asm_clear, win_load, win_consume;

    always_comb begin
        flush       = redirect | entry;
        stall       = beat_q.valid & ~ins_ready;
        par_ready   = ~flush & ~stall;
        fire        = par_valid & par_ready;
        short_slot  = ~half & win_active & win_bit;
        full_word   = {hi, par_data};
        is_pfx      = half & (full_word[WORD_W-1 -: OP_W] == PFX_OP);
        asm_take    = fire & ~half & ~short_slot;
        asm_clear   = flush | (fire & half);
        win_load    = fire & is_pfx;
        win_consume = fire & (short_slot | (half & ~is_pfx));
    end

    mbs_asm #(.PARCEL_W(PARCEL_W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (asm_clear),
        .take   (asm_take),
        .parcel (par_data),
        .half   (half),
        .hi     (hi)
    );

    mbs_window #(.MODE_W(MODE_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .load      (win_load),
        .load_bits (full_word[MODE_LO +: MODE_W]),
        .consume   (win_consume),
        .active    (win_active),
        .cur_bit   (win_bit)
    );

    always_comb begin
        beat_d = beat_q;
        if (fire && (short_slot || half)) begin
            beat_d.valid = 1'b1;
            if (short_slot) begin
                beat_d.kind  = SLOT_SHORT;
                beat_d.word  = {{PARCEL_W{1'b0}}, par_data};
                beat_d.embed = '0;
            end else if (is_pfx) begin
                beat_d.kind  = SLOT_PREFIX;
                beat_d.word  = full_word;
                beat_d.embed = full_word[PARCEL_W-1:0];
            end else begin
                beat_d.kind  = SLOT_LONG;
                beat_d.word  = full_word;
                beat_d.embed = '0;
            end
        end else if (ins_ready) begin
            beat_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign ins_valid  = beat_q.valid;
    assign ins_word   = beat_q.word;
    assign ins_short  = (beat_q.kind == SLOT_SHORT);
    assign ins_prefix = (beat_q.kind == SLOT_PREFIX);
    assign ins_embed  = beat_q.embed;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int              PARCEL_W = 16,
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] PFX_OP   = 6'h3B
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  par_valid,
    input logic                  par_ready,
    input logic                  redirect,
    input logic                  entry,
    input logic                  ins_valid,
    input logic                  ins_ready,
    input logic [2*PARCEL_W-1:0] ins_word,
    input logic                  ins_short,
    input logic                  ins_prefix,
    input logic [PARCEL_W-1:0]   ins_embed
);
    localparam int WORD_W = 2 * PARCEL_W;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=> ins_valid && $stable(ins_word)
            && $stable(ins_short) && $stable(ins_prefix) && $stable(ins_embed));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |-> !par_ready);

    // R7
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect || entry) |-> !par_ready);

    // R4
    short_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_short |-> (ins_word[WORD_W-1:PARCEL_W] == '0) && !ins_prefix);

    // R3
    prefix_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_prefix |-> (ins_word[WORD_W-1 -: OP_W] == PFX_OP)
            && (ins_embed == ins_word[PARCEL_W-1:0]));

    // R2
    emit_after_parcel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_valid) |-> $past(par_valid && par_ready));
endmodule

bind modebit_seq mbs_checker #(
    .PARCEL_W (PARCEL_W),
    .OP_W     (OP_W),
    .PFX_OP   (PFX_OP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_valid  (par_valid),
    .par_ready  (par_ready),
    .redirect   (redirect),
    .entry      (entry),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .ins_word   (ins_word),
    .ins_short  (ins_short),
    .ins_prefix (ins_prefix),
    .ins_embed  (ins_embed)
);

// File: tb/sim_modebit_seq.sv
module sim_modebit_seq;
    localparam logic [5:0] PFX = 6'h3B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_valid = 1'b0;
    logic        par_ready;
    logic [15:0] par_data = '0;
    logic        redirect = 1'b0;
    logic        entry = 1'b0;
    logic        ins_valid;
    logic        ins_ready = 1'b1;
    logic [31:0] ins_word;
    logic        ins_short;
    logic        ins_prefix;
    logic [15:0] ins_embed;

    always #5 clk = ~clk;

    modebit_seq #(.PFX_OP(PFX)) u0 (
        .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_ready(par_ready),
        .par_data(par_data), .redirect(redirect), .entry(entry),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
        .ins_short(ins_short), .ins_prefix(ins_prefix), .ins_embed(ins_embed)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    stall_mode = 1'b0;
    string phase = "R1";

    // reference model state
    bit          m_half;
    logic [15:0] m_hi;
    bit          m_bits[$];
    logic [31:0] e_word[$];
    int          e_kind[$];
    logic [15:0] e_emb[$];
    string       e_tag[$];
    bit          held = 1'b0;
    logic [31:0] p_word;
    logic [15:0] p_emb;
    logic        p_short, p_pfx;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%h expected=%h", tag, what, phase, act, exp);
        end
    endtask

    task automatic finish_run();
        chk(e_word.size() == 0, "R5", "pending expected beats", e_word.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        ins_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            m_half = 0;
            m_bits.delete();
            held = 0;
        end else begin
            if (held) begin
                // R9 beat held while stalled
                chk(ins_valid && ins_word == p_word && ins_short == p_short &&
                    ins_prefix == p_pfx && ins_embed == p_emb,
                    "R9", "stalled beat changed", ins_word, p_word);
            end
            chk(par_ready == (!(redirect || entry) && !(ins_valid && !ins_ready)),
                (redirect || entry) ? "R7" : "R9", "par_ready", par_ready,
                !(redirect || entry) && !(ins_valid && !ins_ready));
            if (ins_valid && ins_ready) begin
                if (e_word.size() == 0) begin
                    chk(0, "R2", "unexpected beat", ins_word, 0);
                end else begin
                    automatic logic [31:0] w = e_word.pop_front();
                    automatic int          k = e_kind.pop_front();
                    automatic logic [15:0] m = e_emb.pop_front();
                    automatic string       t = e_tag.pop_front();
                    chk(ins_word == w, t, "word", ins_word, w);
                    chk({ins_prefix, ins_short} == 2'(k), t, "kind",
                        {ins_prefix, ins_short}, k);
                    chk(ins_embed == m, t, "embed", ins_embed, m);
                end
            end
            held = ins_valid && !ins_ready;
            p_word = ins_word; p_emb = ins_embed; p_short = ins_short; p_pfx = ins_prefix;

            if (redirect || entry) begin
                m_half = 0;
                m_bits.delete();
            end else if (par_valid && par_ready) begin
                if (!m_half) begin
                    if (m_bits.size() > 0 && m_bits[0]) begin
                        void'(m_bits.pop_front());
                        e_word.push_back({16'h0, par_data}); e_kind.push_back(1);
                        e_emb.push_back(16'h0); e_tag.push_back("R4");
                    end else begin
                        m_hi = par_data;
                        m_half = 1;
                    end
                end else begin
                    automatic logic [31:0] w = {m_hi, par_data};
                    m_half = 0;
                    if (w[31:26] == PFX) begin
                        m_bits.delete();
                        for (int i = 25; i >= 16; i--) m_bits.push_back(w[i]);
                        e_word.push_back(w); e_kind.push_back(2);
                        e_emb.push_back(w[15:0]); e_tag.push_back("R3");
                    end else begin
                        e_tag.push_back(m_bits.size() > 0 ? "R4" : "R5");
                        if (m_bits.size() > 0) void'(m_bits.pop_front());
                        e_word.push_back(w); e_kind.push_back(0);
                        e_emb.push_back(16'h0);
                    end
                end
            end
        end
    end

    task automatic send(input logic [15:0] p);
        bit acc;
        par_valid = 1'b1;
        par_data  = p;
        do begin
            @(negedge clk);
            acc = par_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        par_valid = 1'b0;
    endtask

    task automatic send32(input logic [31:0] w);
        send(w[31:16]);
        send(w[15:0]);
    endtask

    task automatic prefix(input logic [9:0] mask, input logic [15:0] emb);
        send32({PFX, mask, emb});
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse(input bit is_entry);
        if (is_entry) entry = 1'b1; else redirect = 1'b1;
        @(posedge clk); #1;
        entry = 1'b0; redirect = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ins_valid == 0, "R1", "ins_valid after reset", ins_valid, 0);
        chk(par_ready == 1, "R1", "par_ready after reset", par_ready, 1);
        @(posedge clk); #1;

        phase = "R2";
        send(16'hA1B2);
        @(negedge clk);
        chk(ins_valid == 0, "R2", "emitted after one parcel", ins_valid, 0);
        @(posedge clk); #1;
        send(16'hC3D4);
        send32(32'h1234_5678);
        idle(3);

        phase = "R5";
        prefix(10'b10_1000_0001, 16'hBEEF);
        send(16'h0101);                 // slot 1 short
        send32(32'h2222_0002);          // slot 2 long
        send(16'h0303);                 // slot 3 short
        for (int i = 4; i <= 9; i++) send32(32'h4000_0000 + i);
        send(16'h0A0A);                 // slot 10 short
        send32(32'h5555_000B);          // eleventh: long
        send32(32'h5555_000C);
        idle(3);

        phase = "R6";
        prefix(10'b11_0111_1111, 16'h1111);
        send(16'h0001);
        send(16'h0002);
        prefix(10'b00_0000_0001, 16'h2222);
        send32(32'h6666_0001);          // new mask bit 0 -> long
        for (int i = 2; i <= 9; i++) send32(32'h6666_0000 + i);
        send(16'h0010);                 // tenth short
        send32(32'h6666_00FF);
        idle(3);

        phase = "R10";
        prefix(10'b11_0000_0000, 16'h3333);
        send({PFX, 10'h3FF});           // short slot carrying the opcode
        send(16'h0022);
        send32(32'h7777_0001);          // long: not loaded by the short parcel
        idle(3);

        phase = "R7";
        prefix(10'b01_1111_1111, 16'h4444);
        send(16'hDEAD);                 // held first half
        pulse(1'b0);
        send32(32'h8888_0001);          // long after redirect
        send32(32'h8888_0002);
        idle(3);

        phase = "R8";
        prefix(10'b11_1111_1111, 16'h5555);
        send(16'h0031);
        pulse(1'b1);
        send32(32'h9999_0001);
        send(16'hFACE);
        pulse(1'b1);
        send32(32'h9999_0002);
        idle(3);

        phase = "R9";
        stall_mode = 1'b1;
        prefix(10'b10_1010_1010, 16'h6666);
        for (int i = 0; i < 10; i++) begin
            if (i % 2 == 0) send(16'h0100 + 16'(i));
            else send32(32'hAAAA_0000 + i);
        end
        send32(32'hAAAA_00FF);
        idle(10);
        stall_mode = 1'b0;
        idle(5);
        finish_run();
    end
endmodule